// File: doc/BRIEF.md
# Dual-Slot Integer Issue Queue

This block holds up to four decoded integer instructions between a two-wide dispatch stage and four execution units: two simple units (SU1 and SU2), a multiply/divide unit (MD) and a load/store unit (LS). Each cycle, dispatch may write in up to two instructions. Only the two oldest entries compete for issue. Each of those two slots has its own fixed set of destination units. The younger slot may issue while the older one is stuck, so a long divide in the bottom slot does not hold back a load or a simple op just above it.

Every instruction carries a 2-bit class and an operand-ready bit. A per-position wake input can set the ready bit of an entry that is already stored. An entry issues only when its target unit reports a free reservation station. After issue, the entries that remain slide down and keep their age order. Newly accepted instructions are placed above them in the same cycle. Dispatch sees how many entries it may send (0, 1 or 2). A request larger than that is refused as a whole. A synchronous flush empties the queue, and it overrides issue and enqueue in its cycle.

Top module: `int_issue_queue`

## Requirements
- R1: After reset the queue is empty. `free_slots` reads 2, `enq_ok` is high when no lane requests, and `iss_vld` is 0.
- R2: Dispatch lanes are marked by `enq_vld[0]` and `enq_vld[1]`, and either or both may be set in a cycle. When both lanes are accepted, lane 0 is older than lane 1. Lane j supplies class `enq_cls[2j+1:2j]`, ready bit `enq_rdy[j]` and payload `enq_data[j*DATA_W +: DATA_W]`.
- R3: When the number of requesting lanes exceeds `free_slots`, `enq_ok` is low and neither lane is written. A partial enqueue never happens.
- R4: Only positions 0 and 1 may issue. Class codes are 00 = SU1 only, 01 = either simple unit, 10 = MD, 11 = LS. Unit codes are 0 = SU1, 1 = SU2, 2 = MD, 3 = LS. Position 0 reports its unit on `iss_unit[1:0]` and its payload on `iss_data[DATA_W-1:0]`, and it sends classes 00 and 01 to unit 0, class 10 to unit 2 and class 11 to unit 3.
- R5: Position 1 reports on `iss_unit[3:2]` and on the upper payload half. It sends class 01 to unit 1, class 10 to unit 2 and class 11 to unit 3. A class 00 entry never issues from position 1.
- R6: An entry issues only when it is valid, its ready bit is set, and `rs_free[unit]` is high for its target unit.
- R7: Position 1 issues whenever its own conditions hold, even if position 0 does not issue.
- R8: When both positions could issue to the same unit (MD or LS), position 0 issues and position 1 waits.
- R9: Issued entries are removed. Survivors move down in age order, and accepted lanes are appended directly above them in the same cycle.
- R10: `free_slots` equals the smaller of 2 and the number of empty entries. It is computed from the occupancy at the start of the cycle, and issues in that same cycle do not add to it.
- R11: While `flush` is high, `iss_vld` is 0 and `enq_ok` is low, and in the next cycle the queue is empty.
- R12: `opnd_wake[i]` sets the ready bit of the entry at position i. The entry can issue from the next cycle, and its new position follows any compaction. A wake bit on an empty position has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empty the queue; overrides issue and enqueue |
| enq_vld | input | 2 | Per-lane enqueue request |
| enq_cls | input | 4 | Per-lane instruction class |
| enq_rdy | input | 2 | Per-lane operand-ready bit |
| enq_data | input | 2*DATA_W | Per-lane instruction payload |
| opnd_wake | input | DEPTH | Set ready bit of stored entry by position |
| rs_free | input | 4 | Reservation station free, indexed by unit code |
| free_slots | output | 2 | Entries dispatch may send this cycle |
| enq_ok | output | 1 | Request accepted in full this cycle |
| iss_vld | output | 2 | Issue strobe for positions 0 and 1 |
| iss_unit | output | 4 | Target unit code for each issuing position |
| iss_data | output | 2*DATA_W | Payloads of positions 0 and 1 |

## Verification
Some rules are checked by assertions on every clock:
- Position 1 never reaches SU1.
- Every issue has a free reservation station.
- The two slots never take the same unit.
- Occupancy follows issue, enqueue and refusal.
- Valid entries stay packed at the bottom.
- The queue is empty after a flush.

Other behaviour only shows up in the bench's scenarios, where each output is compared every cycle against a behavioural model. This covers age order across compaction and appending, which payload comes out in which slot, entry 0 winning a conflict for MD, a load passing a divide stalled on a busy MD, and wake bits that follow an entry after it moves.

// File: rtl/iq_pkg.sv
package iq_pkg;
   // Instruction class codes
   localparam logic [1:0] CLS_SU1ONLY = 2'b00;
   localparam logic [1:0] CLS_SIMPLE  = 2'b01;
   localparam logic [1:0] CLS_MULDIV  = 2'b10;
   localparam logic [1:0] CLS_LDST    = 2'b11;

   // Execution unit codes (index into rs_free)
   localparam logic [1:0] U_SU1 = 2'd0;
   localparam logic [1:0] U_SU2 = 2'd1;
   localparam logic [1:0] U_MD  = 2'd2;
   localparam logic [1:0] U_LS  = 2'd3;

   localparam int NUM_UNITS   = 4;
   localparam int ISSUE_SLOTS = 2;
   localparam int ENQ_LANES   = 2;
endpackage

// File: rtl/iq_slot_pick.sv
module iq_slot_pick
   import iq_pkg::*;
#(
   parameter int SLOT = 0
) (
   input  logic                 vld,
   input  logic                 rdy,
   input  logic [1:0]           cls,
   input  logic [NUM_UNITS-1:0] rs_free,
   output logic                 want,
   output logic [1:0]           unit
);
   logic legal;

   generate
      if (SLOT == 0) begin : g_bottom
         always_comb begin
            legal = 1'b1;
            unique case (cls)
               CLS_MULDIV: unit = U_MD;
               CLS_LDST:   unit = U_LS;
               default:    unit = U_SU1;
            endcase
         end
      end else if (SLOT == 1) begin : g_upper
         always_comb begin
            legal = (cls != CLS_SU1ONLY);
            unique case (cls)
               CLS_MULDIV: unit = U_MD;
               CLS_LDST:   unit = U_LS;
               default:    unit = U_SU2;
            endcase
         end
      end else begin : g_bad_slot
         $error("iq_slot_pick: SLOT must be 0 or 1");
         assign legal = 1'b0;
         assign unit  = U_SU1;
      end
   endgenerate

   assign want = vld & rdy & legal & rs_free[unit];
endmodule

// File: rtl/iq_compact.sv
module iq_compact #(
   parameter int DEPTH  = 4,
   parameter int DATA_W = 16
) (
   input  logic                    flush,
   input  logic [DEPTH-1:0]        cur_v,
   input  logic [2*DEPTH-1:0]      cur_c,
   input  logic [DEPTH-1:0]        cur_r,
   input  logic [DATA_W*DEPTH-1:0] cur_d,
   input  logic [DEPTH-1:0]        wake,
   input  logic [DEPTH-1:0]        remove,
   input  logic [1:0]              add_vld,
   input  logic [3:0]              add_cls,
   input  logic [1:0]              add_rdy,
   input  logic [2*DATA_W-1:0]     add_data,
   output logic [DEPTH-1:0]        nxt_v,
   output logic [2*DEPTH-1:0]      nxt_c,
   output logic [DEPTH-1:0]        nxt_r,
   output logic [DATA_W*DEPTH-1:0] nxt_d
);
   logic [DEPTH-1:0] surv;
   int               spos [DEPTH];
   int               apos [2];
   int               nsurv;

   assign surv = cur_v & ~remove;

   // Destination index of each survivor and each appended lane
   always_comb begin
      nsurv = 0;
      for (int i = 0; i < DEPTH; i++) begin
         spos[i] = nsurv;
         if (surv[i]) nsurv = nsurv + 1;
      end
      apos[0] = nsurv;
      apos[1] = nsurv + (add_vld[0] ? 1 : 0);
   end

   // Gather network: each destination picks its unique source
   always_comb begin
      nxt_v = '0;
      nxt_c = '0;
      nxt_r = '0;
      nxt_d = '0;
      for (int p = 0; p < DEPTH; p++) begin
         for (int i = 0; i < DEPTH; i++) begin
            if (surv[i] && spos[i] == p) begin
               nxt_v[p]                   = 1'b1;
               nxt_c[2*p +: 2]            = cur_c[2*i +: 2];
               nxt_r[p]                   = cur_r[i] | wake[i];
               nxt_d[DATA_W*p +: DATA_W]  = cur_d[DATA_W*i +: DATA_W];
            end
         end
         for (int j = 0; j < 2; j++) begin
            if (add_vld[j] && apos[j] == p) begin
               nxt_v[p]                   = 1'b1;
               nxt_c[2*p +: 2]            = add_cls[2*j +: 2];
               nxt_r[p]                   = add_rdy[j];
               nxt_d[DATA_W*p +: DATA_W]  = add_data[DATA_W*j +: DATA_W];
            end
         end
      end
      if (flush) begin
         nxt_v = '0;
         nxt_c = '0;
         nxt_r = '0;
         nxt_d = '0;
      end
   end
endmodule

// File: rtl/int_issue_queue.sv
module int_issue_queue
   import iq_pkg::*;
#(
   parameter int DEPTH  = 4,
   parameter int DATA_W = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 flush,
   input  logic [1:0]           enq_vld,
   input  logic [3:0]           enq_cls,
   input  logic [1:0]           enq_rdy,
   input  logic [2*DATA_W-1:0]  enq_data,
   input  logic [DEPTH-1:0]     opnd_wake,
   input  logic [3:0]           rs_free,
   output logic [1:0]           free_slots,
   output logic                 enq_ok,
   output logic [1:0]           iss_vld,
   output logic [3:0]           iss_unit,
   output logic [2*DATA_W-1:0]  iss_data
);
   localparam int OCC_W = $clog2(DEPTH + 1);

   generate
      if (DEPTH < ISSUE_SLOTS) begin : g_depth_chk
         $error("int_issue_queue: DEPTH must cover both issue slots");
      end
      if (DATA_W < 1) begin : g_width_chk
         $error("int_issue_queue: DATA_W must be positive");
      end
   endgenerate

   // Entry storage, position 0 is the oldest
   logic [DEPTH-1:0]        q_v, n_v;
   logic [2*DEPTH-1:0]      q_c, n_c;
   logic [DEPTH-1:0]        q_r, n_r;
   logic [DATA_W*DEPTH-1:0] q_d, n_d;

   logic [OCC_W-1:0] occ;
   logic [OCC_W-1:0] free_cnt;
   logic [1:0]       req;
   logic [1:0]       add_vld;
   logic [1:0]       want;
   logic [3:0]       unit;
   logic             clash;
   logic [DEPTH-1:0] remove;

   assign occ      = OCC_W'($countones(q_v));
   assign free_cnt = OCC_W'(DEPTH) - occ;
   assign free_slots = (free_cnt >= OCC_W'(2)) ? 2'd2 : free_cnt[1:0];

   assign req     = {1'b0, enq_vld[0]} + {1'b0, enq_vld[1]};
   assign enq_ok  = !flush && (req <= free_slots);
   assign add_vld = enq_ok ? enq_vld : 2'b00;

   // Per-slot steering
   for (genvar s = 0; s < ISSUE_SLOTS; s++) begin : g_pick
      iq_slot_pick #(.SLOT(s)) u_pick (
         .vld     (q_v[s]),
         .rdy     (q_r[s]),
         .cls     (q_c[2*s +: 2]),
         .rs_free (rs_free),
         .want    (want[s]),
         .unit    (unit[2*s +: 2])
      );
   end

   // Older slot wins a shared unit
   assign clash      = want[0] && (unit[1:0] == unit[3:2]);
   assign iss_vld[0] = want[0] && !flush;
   assign iss_vld[1] = want[1] && !flush && !clash;
   assign iss_unit   = unit;
   assign iss_data   = q_d[2*DATA_W-1:0];

   always_comb begin
      remove      = '0;
      remove[1:0] = iss_vld;
   end

   iq_compact #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_compact (
      .flush    (flush),
      .cur_v    (q_v),
      .cur_c    (q_c),
      .cur_r    (q_r),
      .cur_d    (q_d),
      .wake     (opnd_wake),
      .remove   (remove),
      .add_vld  (add_vld),
      .add_cls  (enq_cls),
      .add_rdy  (enq_rdy),
      .add_data (enq_data),
      .nxt_v    (n_v),
      .nxt_c    (n_c),
      .nxt_r    (n_r),
      .nxt_d    (n_d)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q_v <= '0;
         q_c <= '0;
         q_r <= '0;
         q_d <= '0;
      end else begin
         q_v <= n_v;
         q_c <= n_c;
         q_r <= n_r;
         q_d <= n_d;
      end
   end

   // ---------------- assertions ----------------
   assert_slot1_route_R5: assert property (@(posedge clk) disable iff (!rst_n)
      iss_vld[1] |-> (iss_unit[3:2] != U_SU1));

   assert_rs_free0_R6: assert property (@(posedge clk) disable iff (!rst_n)
      iss_vld[0] |-> rs_free[iss_unit[1:0]]);

   assert_rs_free1_R6: assert property (@(posedge clk) disable iff (!rst_n)
      iss_vld[1] |-> rs_free[iss_unit[3:2]]);

   assert_one_per_unit_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (&iss_vld) |-> (iss_unit[1:0] != iss_unit[3:2]));

   assert_flush_empty_R11: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (occ == '0));

   assert_refuse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!flush && !enq_ok && iss_vld == 2'b00) |=> (occ == $past(occ)));

   assert_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !flush |=> (int'(occ) == int'($past(occ)) - $countones($past(iss_vld))
                                + $countones($past(add_vld))));

   assert_packed_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ((q_v + DEPTH'(1)) & q_v) == '0);
endmodule

// File: tb/tb_int_issue_queue.sv
`timescale 1ns/1ps
module tb_int_issue_queue;
   localparam int DEPTH  = 4;
   localparam int DATA_W = 16;

   logic                clk = 1'b0;
   logic                rst_n;
   logic                flush;
   logic [1:0]          enq_vld;
   logic [3:0]          enq_cls;
   logic [1:0]          enq_rdy;
   logic [2*DATA_W-1:0] enq_data;
   logic [DEPTH-1:0]    opnd_wake;
   logic [3:0]          rs_free;
   logic [1:0]          free_slots;
   logic                enq_ok;
   logic [1:0]          iss_vld;
   logic [3:0]          iss_unit;
   logic [2*DATA_W-1:0] iss_data;

   int  n_chk = 0;
   int  n_err = 0;
   bit  done  = 0;

   // Behavioural model
   int m_c [DEPTH];
   int m_r [DEPTH];
   int m_d [DEPTH];
   int m_n = 0;

   always #2.5 clk = ~clk;

   int_issue_queue #(.DEPTH(DEPTH), .DATA_W(DATA_W)) dut (
      .clk, .rst_n, .flush, .enq_vld, .enq_cls, .enq_rdy, .enq_data,
      .opnd_wake, .rs_free, .free_slots, .enq_ok, .iss_vld, .iss_unit, .iss_data
   );

   task automatic chk(input string tag, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic step(input string tag, input bit fl, input logic [1:0] ev,
                       input int c0, input int c1, input logic [1:0] rd,
                       input int d0, input int d1, input logic [3:0] wk,
                       input logic [3:0] rs);
      int  u0, nfree, req, k;
      bit  w0, w1, i0, i1, ok;
      int  t_c [DEPTH];
      int  t_r [DEPTH];
      int  t_d [DEPTH];
      @(negedge clk);
      flush     = fl;
      enq_vld   = ev;
      enq_cls   = {c1[1:0], c0[1:0]};
      enq_rdy   = rd;
      enq_data  = {d1[DATA_W-1:0], d0[DATA_W-1:0]};
      opnd_wake = wk;
      rs_free   = rs;
      #1;
      u0 = (m_c[0] >= 2) ? m_c[0] : 0;
      w0 = (m_n > 0) && (m_r[0] != 0) && rs[u0];
      w1 = (m_n > 1) && (m_r[1] != 0) && (m_c[1] != 0) && rs[m_c[1]];
      i0 = w0 && !fl;
      i1 = w1 && !fl && !(w0 && u0 == m_c[1]);
      nfree = (DEPTH - m_n > 2) ? 2 : DEPTH - m_n;
      req = int'(ev[0]) + int'(ev[1]);
      ok = !fl && (req <= nfree);
      chk(tag, "free_slots", int'(free_slots), nfree);
      chk(tag, "enq_ok", int'(enq_ok), int'(ok));
      chk(tag, "iss_vld", int'(iss_vld), int'({i1, i0}));
      if (i0) begin
         chk(tag, "unit0", int'(iss_unit[1:0]), u0);
         chk(tag, "data0", int'(iss_data[DATA_W-1:0]), m_d[0]);
      end
      if (i1) begin
         chk(tag, "unit1", int'(iss_unit[3:2]), m_c[1]);
         chk(tag, "data1", int'(iss_data[2*DATA_W-1:DATA_W]), m_d[1]);
      end
      // model update
      if (fl) begin
         m_n = 0;
      end else begin
         k = 0;
         for (int i = 0; i < m_n; i++) begin
            if (!((i == 0 && i0) || (i == 1 && i1))) begin
               t_c[k] = m_c[i];
               t_r[k] = (m_r[i] != 0 || wk[i]) ? 1 : 0;
               t_d[k] = m_d[i];
               k++;
            end
         end
         if (ok && ev[0]) begin
            t_c[k] = c0 & 3; t_r[k] = int'(rd[0]); t_d[k] = d0 & 16'hFFFF; k++;
         end
         if (ok && ev[1]) begin
            t_c[k] = c1 & 3; t_r[k] = int'(rd[1]); t_d[k] = d1 & 16'hFFFF; k++;
         end
         for (int i = 0; i < k; i++) begin
            m_c[i] = t_c[i]; m_r[i] = t_r[i]; m_d[i] = t_d[i];
         end
         m_n = k;
      end
   endtask

   task automatic idle(input string tag, input logic [3:0] rs);
      step(tag, 0, 2'b00, 0, 0, 2'b00, 0, 0, 4'h0, rs);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_err++;
         n_chk++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      rst_n = 0; flush = 0; enq_vld = 0; enq_cls = 0; enq_rdy = 0;
      enq_data = 0; opnd_wake = 0; rs_free = 0;
      repeat (4) @(negedge clk);
      rst_n = 1;

      idle("R1", 4'h0);
      // fill with four not-ready entries
      step("R2", 0, 2'b11, 0, 1, 2'b00, 'hA0, 'hB0, 4'h0, 4'h0);
      step("R2", 0, 2'b11, 2, 3, 2'b00, 'hC0, 'hD0, 4'h0, 4'h0);
      idle("R10", 4'h0);
      // refused while full
      step("R3", 0, 2'b01, 1, 0, 2'b01, 'hE0, 0, 4'h0, 4'hF);
      step("R3", 0, 2'b10, 0, 1, 2'b10, 0, 'hE1, 4'h0, 4'hF);
      // wake B, then it passes A from slot 1
      step("R12", 0, 2'b00, 0, 0, 2'b00, 0, 0, 4'b0010, 4'h0);
      idle("R7", 4'b0010);
      // wake A and C, both issue
      step("R12", 0, 2'b00, 0, 0, 2'b00, 0, 0, 4'b0011, 4'h0);
      idle("R4", 4'hF);
      // flush with a request and free stations
      step("R11", 1, 2'b11, 1, 1, 2'b11, 'h11, 'h12, 4'hF, 4'hF);
      idle("R11", 4'hF);
      // two MD ops compete
      step("R8", 0, 2'b11, 2, 2, 2'b11, 'h21, 'h22, 4'h0, 4'h0);
      idle("R8", 4'hF);
      idle("R8", 4'hF);
      // SU1-only in slot 1 waits
      step("R5", 0, 2'b11, 0, 0, 2'b11, 'h31, 'h32, 4'h0, 4'h0);
      idle("R5", 4'hF);
      idle("R5", 4'hF);
      // LS with busy station
      step("R6", 0, 2'b01, 3, 0, 2'b01, 'h41, 0, 4'h0, 4'h0);
      idle("R6", 4'b0111);
      step("R11", 1, 2'b00, 0, 0, 2'b00, 0, 0, 4'h0, 4'h0);
      // load passes stalled divide
      step("R7", 0, 2'b11, 2, 3, 2'b11, 'h51, 'h52, 4'h0, 4'h0);
      idle("R7", 4'b1011);
      idle("R7", 4'hF);
      // lane 1 alone
      step("R2", 0, 2'b10, 0, 1, 2'b10, 0, 'h61, 4'h0, 4'h0);
      idle("R2", 4'hF);

      for (int n = 0; n < 4000; n++) begin
         step("R9", ($urandom % 40) == 0, 2'($urandom), int'($urandom % 4), int'($urandom % 4),
              2'($urandom), int'($urandom % 65536), int'($urandom % 65536),
              4'($urandom & $urandom), 4'($urandom));
      end

      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule